// File: doc/BRIEF.md
# Flash Command Controller with Erase Suspend

This block is the command front end and status keeper of a behavioural flash memory. A host issues bus write cycles (address, data byte, write strobe). The controller turns each strobe rising edge into one accepted write and decodes the data byte as a command. It runs a two-write byte program and a two-write block erase. Each operation spends a parameterised number of clock cycles in a busy state and then updates a small on-chip array. The array is held in flip-flops and reset to the erased value.

An erase in progress can be suspended, with its remaining time frozen. While suspended, the host may program a location elsewhere and then resume the erase. A resume issued while that nested program is still running is remembered and takes effect only when the program finishes.

The status byte has these bits:

| Bit | Meaning |
|---|---|
| 7 | Ready |
| 6 | Erase suspended |
| 5 | Erase or sequence error |
| 4 | Program error |
| 3 | Supply too low |
| 1 | Block locked |

The ready/busy pin follows bit 7. Per-block lock bits are loaded through a test port. Supply sensing is a single input flag.

FSM states and transitions:

- **IDLE**
  - 40h or 10h → PGM_SETUP
  - 20h → ERS_SETUP
- **PGM_SETUP**
  - a data write with no fault → PGM_BUSY
  - a data write with a fault → IDLE
- **ERS_SETUP**
  - D0h with no fault → ERS_BUSY
  - anything else, or a fault → IDLE
- **PGM_BUSY**
  - timer done → IDLE
- **ERS_BUSY**
  - timer done → IDLE
  - B0h → SUSP
- **SUSP**
  - D0h → ERS_BUSY
  - 40h or 10h → SUSP_PGM_SETUP
- **SUSP_PGM_SETUP**
  - a data write with no fault → SUSP_PGM_BUSY
  - a data write with a fault → SUSP
- **SUSP_PGM_BUSY**
  - timer done with a resume pending → ERS_BUSY
  - timer done with no resume pending → SUSP

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, rdy_bsy is 1, reads return array data (every byte erased to FFh), and after a 70h command a read returns 80h.
- R2: A program is a write of 40h or 10h followed by a write carrying address and data. The addressed byte becomes its old value AND the data.
- R3: After a program or erase sequence, or a 70h command, reads return the status byte regardless of address. This holds until FFh returns reads to the array.
- R4: Status bit 7 and rdy_bsy are 0 for exactly PROG_CYC cycles after a program data write, or ERASE_CYC cycles after an erase confirm. Both are 1 otherwise.
- R5: A data bit of 1 over a stored 0 leaves the bit at 0. It does not set status bit 4.
- R6: With vpp_ok low, a program data write sets status bits 4 and 3, and an erase confirm sets bits 5 and 3. The array is unchanged and no busy period follows.
- R7: When the target block's lock bit is set, a program sets status bits 4 and 1, and an erase sets bits 5 and 1. The array is unchanged.
- R8: An erase is 20h followed by D0h at an address in the block, where the block is bus_addr[AW-1:BLK_AW]. Every byte of that block becomes FFh and other blocks are untouched.
- R9: B0h during an erase suspends it. rdy_bsy goes to 1, the status byte shows bits 7 and 6 set, and the erase's remaining time is frozen.
- R10: While suspended, only 98h, 70h, 50h, B8h, D0h, 40h and 10h are accepted. Any other byte sets status bits 5 and 4 and leaves the erase suspended.
- R11: D0h while suspended resumes the erase. Status bits 7 and 6 clear and rdy_bsy returns to 0 on the next cycle.
- R12: D0h written while a program started during suspend is still busy is held. The erase resumes when that program completes, with no further command.
- R13: In idle, or as the second write of an erase, any byte outside the accepted set sets status bits 5 and 4. Here 98h and B8h are accepted no-ops.
- R14: Status bits 5, 4, 3 and 1 stay set until a 50h command clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | AW | Address for writes and reads |
| bus_wdata | input | DW | Command or program data |
| wr_stb | input | 1 | Write strobe; a write is taken on its rising edge |
| vpp_ok | input | 1 | 1 when the programming supply is adequate |
| lock_wr | input | 1 | Test port: load one block lock bit |
| lock_blk | input | AW-BLK_AW | Test port: block index |
| lock_val | input | 1 | Test port: lock bit value |
| rd_data | output | DW | Array byte or status byte, per read mode |
| rdy_bsy | output | 1 | 1 ready, 0 busy |

## Verification
A wrong state shows within one cycle on rdy_bsy or on the status byte. Examples are a suspend that is not taken, or a resume that fires while the nested program is busy. A timer that keeps running during suspend is visible only through later erase timing and the array contents. A wrong busy length shows as a cycle count on rdy_bsy that differs from the parameter. A mis-decoded command shows as error bits 5 and 4 in the status byte, or as an array byte that changed when it should not have.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGM_SETUP,
        ST_ERS_SETUP,
        ST_PGM_BUSY,
        ST_ERS_BUSY,
        ST_SUSP,
        ST_SUSP_PGM_SETUP,
        ST_SUSP_PGM_BUSY
    } fsm_state_t;

    typedef enum logic {
        RD_ARRAY,
        RD_STATUS
    } rd_mode_t;

    typedef struct packed {
        logic seq_ers;   // status bit 5
        logic pgm;       // status bit 4
        logic vlow;      // status bit 3
        logic lock;      // status bit 1
    } err_bits_t;

    localparam logic [7:0] CMD_PGM_A   = 8'h40;
    localparam logic [7:0] CMD_PGM_B   = 8'h10;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_RDSTAT  = 8'h70;
    localparam logic [7:0] CMD_RDARR   = 8'hFF;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_CONFIG  = 8'hB8;

endpackage

// File: rtl/op_timer.sv
`timescale 1ns/1ps
module op_timer #(
    parameter int CYC = 4,
    parameter int CW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    output logic          done,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYC - 1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/lock_bits.sv
`timescale 1ns/1ps
module lock_bits #(
    parameter int NBLK = 4,
    parameter int BW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [BW-1:0] set_blk,
    input  logic          set_val,
    input  logic [BW-1:0] q_blk,
    output logic          q_locked
);
    logic [NBLK-1:0] bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (set_en) begin
            bits[set_blk] <= set_val;
        end
    end

    assign q_locked = bits[q_blk];
endmodule

// File: rtl/flash_array.sv
`timescale 1ns/1ps
module flash_array #(
    parameter int AW     = 6,
    parameter int BLK_AW = 4,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pgm_en,
    input  logic [AW-1:0]        pgm_addr,
    input  logic [DW-1:0]        pgm_data,
    input  logic                 ers_en,
    input  logic [AW-BLK_AW-1:0] ers_blk,
    input  logic [AW-1:0]        rd_addr,
    output logic [DW-1:0]        rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic [AW-1:0]        MY_ADDR = AW'(i);
        localparam logic [AW-BLK_AW-1:0] MY_BLK  = MY_ADDR[AW-1:BLK_AW];
        logic [DW-1:0] val;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val <= '1;
            end else if (ers_en && ers_blk == MY_BLK) begin
                val <= '1;
            end else if (pgm_en && pgm_addr == MY_ADDR) begin
                val <= val & pgm_data;
            end
        end

        assign cells[i] = val;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int AW        = 6,
    parameter int BLK_AW    = 4,
    parameter int DW        = 8,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 wr_stb,
    input  logic                 vpp_ok,
    input  logic                 lock_wr,
    input  logic [AW-BLK_AW-1:0] lock_blk,
    input  logic                 lock_val,
    output logic [DW-1:0]        rd_data,
    output logic                 rdy_bsy
);
    localparam int BW   = AW - BLK_AW;
    localparam int NBLK = 1 << BW;
    localparam int PCW  = $clog2(PROG_CYC + 1);
    localparam int ECW  = $clog2(ERASE_CYC + 1);

    fsm_state_t state, nxt;
    rd_mode_t   rmode, rmode_n;
    err_bits_t  err, err_n;
    logic       resume_pend, pend_n;

    logic          stb_q, wr_acc;
    logic [7:0]    cmd;
    logic          lock_hit, pgm_fault;
    logic          pgm_start, ers_start, pgm_run, ers_run, pgm_done, ers_done;
    logic          latch_pgm, latch_ers;
    logic [PCW-1:0] pgm_cnt;
    logic [ECW-1:0] ers_cnt;
    logic [AW-1:0] pgm_addr_q;
    logic [DW-1:0] pgm_data_q;
    logic [BW-1:0] ers_blk_q;
    logic [DW-1:0] arr_rd;
    logic          ready;
    logic [7:0]    status8;

    assign wr_acc    = wr_stb & ~stb_q;
    assign cmd       = bus_wdata[7:0];
    assign pgm_fault = !vpp_ok || lock_hit;
    assign pgm_run   = (state == ST_PGM_BUSY) || (state == ST_SUSP_PGM_BUSY);
    assign ers_run   = (state == ST_ERS_BUSY);

    lock_bits #(.NBLK(NBLK), .BW(BW)) u_lock (
        .clk(clk), .rst_n(rst_n),
        .set_en(lock_wr), .set_blk(lock_blk), .set_val(lock_val),
        .q_blk(bus_addr[AW-1:BLK_AW]), .q_locked(lock_hit)
    );

    op_timer #(.CYC(PROG_CYC), .CW(PCW)) u_pgm_tmr (
        .clk(clk), .rst_n(rst_n), .start(pgm_start), .run(pgm_run),
        .done(pgm_done), .cnt(pgm_cnt)
    );

    op_timer #(.CYC(ERASE_CYC), .CW(ECW)) u_ers_tmr (
        .clk(clk), .rst_n(rst_n), .start(ers_start), .run(ers_run),
        .done(ers_done), .cnt(ers_cnt)
    );

    flash_array #(.AW(AW), .BLK_AW(BLK_AW), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .pgm_en(pgm_done), .pgm_addr(pgm_addr_q), .pgm_data(pgm_data_q),
        .ers_en(ers_done), .ers_blk(ers_blk_q),
        .rd_addr(bus_addr), .rd_data(arr_rd)
    );

    // next-state and register updates
    always_comb begin
        nxt       = state;
        rmode_n   = rmode;
        err_n     = err;
        pend_n    = resume_pend;
        pgm_start = 1'b0;
        ers_start = 1'b0;
        latch_pgm = 1'b0;
        latch_ers = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_acc) begin
                    case (cmd)
                        CMD_PGM_A, CMD_PGM_B: begin
                            nxt     = ST_PGM_SETUP;
                            rmode_n = RD_STATUS;
                        end
                        CMD_ERASE: begin
                            nxt     = ST_ERS_SETUP;
                            rmode_n = RD_STATUS;
                        end
                        CMD_RDSTAT: rmode_n = RD_STATUS;
                        CMD_RDARR:  rmode_n = RD_ARRAY;
                        CMD_CLEAR:  err_n   = '0;
                        CMD_QUERY, CMD_CONFIG: ;
                        default: begin
                            err_n.seq_ers = 1'b1;
                            err_n.pgm     = 1'b1;
                        end
                    endcase
                end
            end
            ST_PGM_SETUP, ST_SUSP_PGM_SETUP: begin
                if (wr_acc) begin
                    rmode_n = RD_STATUS;
                    if (pgm_fault) begin
                        err_n.pgm = 1'b1;
                        if (!vpp_ok) err_n.vlow = 1'b1;
                        if (lock_hit) err_n.lock = 1'b1;
                        nxt = (state == ST_PGM_SETUP) ? ST_IDLE : ST_SUSP;
                    end else begin
                        latch_pgm = 1'b1;
                        pgm_start = 1'b1;
                        nxt = (state == ST_PGM_SETUP) ? ST_PGM_BUSY : ST_SUSP_PGM_BUSY;
                    end
                end
            end
            ST_ERS_SETUP: begin
                if (wr_acc) begin
                    rmode_n = RD_STATUS;
                    nxt     = ST_IDLE;
                    if (cmd != CMD_CONFIRM) begin
                        err_n.seq_ers = 1'b1;
                        err_n.pgm     = 1'b1;
                    end else if (pgm_fault) begin
                        err_n.seq_ers = 1'b1;
                        if (!vpp_ok) err_n.vlow = 1'b1;
                        if (lock_hit) err_n.lock = 1'b1;
                    end else begin
                        latch_ers = 1'b1;
                        ers_start = 1'b1;
                        nxt       = ST_ERS_BUSY;
                    end
                end
            end
            ST_PGM_BUSY: begin
                if (pgm_done) nxt = ST_IDLE;
            end
            ST_ERS_BUSY: begin
                if (ers_done) begin
                    nxt = ST_IDLE;
                end else if (wr_acc && cmd == CMD_SUSPEND) begin
                    nxt = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (wr_acc) begin
                    case (cmd)
                        CMD_CONFIRM:          nxt = ST_ERS_BUSY;
                        CMD_PGM_A, CMD_PGM_B: nxt = ST_SUSP_PGM_SETUP;
                        CMD_RDSTAT:           rmode_n = RD_STATUS;
                        CMD_CLEAR:            err_n = '0;
                        CMD_QUERY, CMD_CONFIG: ;
                        default: begin
                            err_n.seq_ers = 1'b1;
                            err_n.pgm     = 1'b1;
                        end
                    endcase
                end
            end
            ST_SUSP_PGM_BUSY: begin
                if (wr_acc && cmd == CMD_CONFIRM) pend_n = 1'b1;
                if (pgm_done) begin
                    pend_n = 1'b0;
                    nxt = (resume_pend || (wr_acc && cmd == CMD_CONFIRM))
                          ? ST_ERS_BUSY : ST_SUSP;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // companion registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q       <= 1'b0;
            rmode       <= RD_ARRAY;
            err         <= '0;
            resume_pend <= 1'b0;
            pgm_addr_q  <= '0;
            pgm_data_q  <= '0;
            ers_blk_q   <= '0;
        end else begin
            stb_q       <= wr_stb;
            rmode       <= rmode_n;
            err         <= err_n;
            resume_pend <= pend_n;
            if (latch_pgm) begin
                pgm_addr_q <= bus_addr;
                pgm_data_q <= bus_wdata;
            end
            if (latch_ers) ers_blk_q <= bus_addr[AW-1:BLK_AW];
        end
    end

    // outputs
    always_comb begin
        ready   = !(state == ST_PGM_BUSY || state == ST_ERS_BUSY ||
                    state == ST_SUSP_PGM_BUSY);
        status8 = {ready,
                   (state == ST_SUSP || state == ST_SUSP_PGM_SETUP ||
                    state == ST_SUSP_PGM_BUSY),
                   err.seq_ers, err.pgm, err.vlow, 1'b0, err.lock, 1'b0};
        rdy_bsy = ready;
        rd_data = (rmode == RD_STATUS) ? DW'(status8) : arr_rd;
    end
endmodule

// File: rtl/flash_cmd_chk.sv
`timescale 1ns/1ps
module flash_cmd_chk
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYC = 4,
    parameter int PCW      = 3,
    parameter int ECW      = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_acc,
    input logic [7:0]     cmd,
    input fsm_state_t     state,
    input logic           rdy_bsy,
    input logic           rd_msb,
    input logic [3:0]     err_bits,
    input logic [PCW-1:0] pgm_cnt,
    input logic [ECW-1:0] ers_cnt,
    input logic           lock_hit
);
    localparam int LW = $clog2(PROG_CYC + 2) + 1;
    logic [LW-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_len <= '0;
        else if (state == ST_PGM_BUSY || state == ST_SUSP_PGM_BUSY) busy_len <= busy_len + 1'b1;
        else busy_len <= '0;
    end

    // R3
    busy_reads_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_bsy |-> !rd_msb);

    // R4
    pgm_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= LW'(PROG_CYC));

    // R9
    suspend_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP) |=> $stable(ers_cnt));

    // R12
    resume_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP_PGM_BUSY) |=> $stable(ers_cnt));

    // R12
    nested_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP_PGM_BUSY && pgm_cnt == '0) |=> (state != ST_SUSP_PGM_BUSY));

    // R14
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_bits != 4'b0 && !(wr_acc && cmd == CMD_CLEAR)) |=> (err_bits != 4'b0));

    // R7
    locked_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM_SETUP && wr_acc && lock_hit) |=> rdy_bsy);
endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.PROG_CYC(PROG_CYC), .PCW(PCW), .ECW(ECW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .cmd(bus_wdata[7:0]),
    .state(state), .rdy_bsy(rdy_bsy), .rd_msb(rd_data[7]),
    .err_bits(err), .pgm_cnt(pgm_cnt), .ers_cnt(ers_cnt), .lock_hit(lock_hit)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
    localparam int AW = 6, BLK_AW = 4, DW = 8, PROG_CYC = 4, ERASE_CYC = 20;
    localparam int BW = AW - BLK_AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic wr_stb = 1'b0, vpp_ok = 1'b1, lock_wr = 1'b0, lock_val = 1'b0;
    logic [BW-1:0] lock_blk = '0;
    logic [DW-1:0] rd_data;
    logic rdy_bsy;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(.AW(AW), .BLK_AW(BLK_AW), .DW(DW),
                     .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wr_stb(wr_stb), .vpp_ok(vpp_ok), .lock_wr(lock_wr), .lock_blk(lock_blk),
        .lock_val(lock_val), .rd_data(rd_data), .rdy_bsy(rdy_bsy));

    int n_chk = 0, n_fail = 0;

    typedef struct {
        logic [7:0] exp;
        bit         on_pin;
        string      req;
    } sb_item_t;

    sb_item_t sb_q[$];
    bit sb_pend = 1'b0;

    task automatic note(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin : monitor
        sb_item_t it;
        if (sb_pend && sb_q.size() > 0) begin
            it = sb_q.pop_front();
            note(it.req, it.on_pin ? int'(rdy_bsy) : int'(rd_data), int'(it.exp));
            sb_pend = 1'b0;
        end
    end

    task automatic expect_rd(logic [AW-1:0] addr, logic [7:0] exp, string req);
        sb_item_t it;
        @(posedge clk); #1;
        bus_addr = addr;
        it.exp = exp; it.on_pin = 1'b0; it.req = req;
        sb_q.push_back(it);
        sb_pend = 1'b1;
        wait (!sb_pend);
    endtask

    task automatic expect_rdy(logic exp, string req);
        sb_item_t it;
        @(posedge clk); #1;
        it.exp = {7'b0, exp}; it.on_pin = 1'b1; it.req = req;
        sb_q.push_back(it);
        sb_pend = 1'b1;
        wait (!sb_pend);
    endtask

    task automatic bus_wr(logic [AW-1:0] addr, logic [7:0] data);
        @(posedge clk); #1;
        bus_addr = addr; bus_wdata = data; wr_stb = 1'b1;
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (rdy_bsy) break;
            n++;
        end
    endtask

    task automatic wait_ready();
        int n;
        busy_len(n);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin : driver
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_rd(6'h05, 8'hFF, "R1 erased array");
        expect_rdy(1'b1, "R1 ready pin");
        bus_wr(0, 8'h70);
        expect_rd(6'h05, 8'h80, "R1 status after reset");

        // R2/R4 program with 40h
        bus_wr(0, 8'h40);
        bus_wr(6'h05, 8'h5A);
        busy_len(n);
        note("R4 program busy length", n, PROG_CYC);
        expect_rd(6'h05, 8'h80, "R3 status after program");
        bus_wr(0, 8'hFF);
        expect_rd(6'h05, 8'h5A, "R2 programmed byte");

        // R5 program with 10h, 0->1 bits ignored
        bus_wr(0, 8'h10);
        bus_wr(6'h05, 8'hF0);
        wait_ready();
        expect_rd(6'h05, 8'h80, "R5 no program error");
        bus_wr(0, 8'hFF);
        expect_rd(6'h05, 8'h50, "R5 AND result");

        // R6 low supply
        vpp_ok = 1'b0;
        bus_wr(0, 8'h40);
        bus_wr(6'h06, 8'h00);
        expect_rd(6'h06, 8'h98, "R6 program low supply");
        bus_wr(0, 8'h50);
        bus_wr(0, 8'h20);
        bus_wr(6'h06, 8'hD0);
        expect_rd(6'h06, 8'hA8, "R6 erase low supply");
        vpp_ok = 1'b1;
        bus_wr(0, 8'h50);
        expect_rd(6'h06, 8'h80, "R14 clear");
        bus_wr(0, 8'hFF);
        expect_rd(6'h06, 8'hFF, "R6 array unchanged");

        // R7 locked block 1
        @(posedge clk); #1 lock_wr = 1'b1; lock_blk = 2'd1; lock_val = 1'b1;
        @(posedge clk); #1 lock_wr = 1'b0;
        bus_wr(0, 8'h40);
        bus_wr(6'h12, 8'h00);
        expect_rdy(1'b1, "R7 no busy when locked");
        expect_rd(6'h12, 8'h92, "R7 program locked");
        bus_wr(0, 8'h50);
        bus_wr(0, 8'h20);
        bus_wr(6'h12, 8'hD0);
        expect_rd(6'h12, 8'hA2, "R7 erase locked");
        bus_wr(0, 8'h50);
        bus_wr(0, 8'hFF);
        expect_rd(6'h12, 8'hFF, "R7 array unchanged");

        // R13 / R14 sequence error, sticky
        bus_wr(0, 8'h20);
        bus_wr(0, 8'h33);
        expect_rd(0, 8'hB0, "R13 bad erase confirm");
        bus_wr(0, 8'hFF);
        bus_wr(0, 8'h70);
        expect_rd(0, 8'hB0, "R14 errors sticky");
        bus_wr(0, 8'h50);
        bus_wr(0, 8'h98);
        expect_rd(0, 8'h80, "R13 query is no-op");

        // R8 erase block 0, block 2 untouched
        bus_wr(0, 8'h40);
        bus_wr(6'h25, 8'h11);
        wait_ready();
        bus_wr(0, 8'h20);
        bus_wr(6'h03, 8'hD0);
        busy_len(n);
        note("R4 erase busy length", n, ERASE_CYC);
        bus_wr(0, 8'hFF);
        expect_rd(6'h05, 8'hFF, "R8 block erased");
        expect_rd(6'h25, 8'h11, "R8 other block kept");

        // R9/R10/R12 suspend with nested program and held resume
        bus_wr(0, 8'h40);
        bus_wr(6'h03, 8'h00);
        wait_ready();
        bus_wr(0, 8'h20);
        bus_wr(6'h00, 8'hD0);
        bus_wr(0, 8'hB0);
        expect_rdy(1'b1, "R9 ready in suspend");
        expect_rd(0, 8'hC0, "R9 suspend status");
        repeat (ERASE_CYC + 10) @(posedge clk);
        expect_rd(0, 8'hC0, "R9 still suspended");
        bus_wr(0, 8'hFF);
        expect_rd(0, 8'hF0, "R10 illegal in suspend");
        bus_wr(0, 8'h50);
        bus_wr(0, 8'hB8);
        expect_rd(0, 8'hC0, "R10 clear and configure accepted");
        bus_wr(0, 8'h40);
        bus_wr(6'h26, 8'h01);
        bus_wr(0, 8'hD0);
        expect_rdy(1'b0, "R12 busy during nested program");
        repeat (PROG_CYC + 3) @(posedge clk);
        expect_rd(0, 8'h00, "R12 erase resumed by itself");
        wait_ready();
        expect_rd(0, 8'h80, "R12 erase done");
        bus_wr(0, 8'hFF);
        expect_rd(6'h03, 8'hFF, "R12 erase finished");
        expect_rd(6'h26, 8'h01, "R12 nested program done");

        // R11 plain resume on block 2
        bus_wr(0, 8'h20);
        bus_wr(6'h20, 8'hD0);
        bus_wr(0, 8'hB0);
        expect_rdy(1'b1, "R9 suspend pin");
        bus_wr(0, 8'hD0);
        expect_rdy(1'b0, "R11 busy after resume");
        expect_rd(0, 8'h00, "R11 bits 7 and 6 cleared");
        wait_ready();
        bus_wr(0, 8'hFF);
        expect_rd(6'h25, 8'hFF, "R11 resumed erase done");

        summary();
        $finish;
    end
endmodule